// File: doc/BRIEF.md
# Two-Stage Verified Bloom Membership Tester

The block tells whether a fixed-width key belongs to a set that was loaded into it earlier. Each key is hashed by K independent universal (H3-class) hash units. Each unit computes a bit index as the XOR of fixed coefficients, one coefficient for each key bit that is 1. Programming a key sets the K addressed bits of a primary bit vector of M bits. It also sets one bit of a second M-bit reference vector. That bit is addressed by the XOR of the K primary indices.

A query first tests the K primary bits. A miss there ends the lookup, and the reference vector is not addressed. A primary hit is then confirmed against the reference bit, which removes most primary false positives. Every query gives exactly one result strobe, two cycles after it is presented, whether it hit or missed. A clear request wipes both vectors one index per cycle. Busy is raised while the clear runs, and programs and queries are ignored during that time.

Top module: `bloom_ref_filter`

## Requirements
- R1: Hash unit s (0-based, s < K) maps a key to the XOR of coefficient c(s,b) over every key bit b that is 1 (an all-zero key maps to 0). c(s,b) is the upper log2(M) bits of the low 32 bits of the product (256*s + b + 1) * 0x9E3779B1.
- R2: A program strobe accepted at a clock edge sets the primary bits at all K hash indices. It also sets the reference bit at the XOR of those K indices. A query presented in any later cycle sees the new contents.
- R3: A query presented in the cycle before clock edge E produces res_valid_o high for exactly one cycle, in the cycle after edge E+1. Queries on consecutive cycles each produce their own strobe on consecutive cycles.
- R4: res_hit_o is 1 exactly when all K primary bits addressed by the query key are set. A key that has been programmed always reports res_hit_o = 1.
- R5: res_match_o is 1 exactly when res_hit_o is 1 and the reference bit at the XOR of the K indices is set. A key whose primary bits are all set but whose reference bit is clear reports res_hit_o = 1 and res_match_o = 0.
- R6: A primary miss reports res_hit_o = 0 and res_match_o = 0 with the same latency as a hit.
- R7: res_hit_o and res_match_o are 0 whenever res_valid_o is 0.
- R8: clr_i, when sampled high while idle, raises busy_o for exactly M cycles, starting the cycle after that edge. Afterwards both vectors are all zero, so every query misses.
- R9: While busy_o is high, or in a cycle where clr_i is high, program and query strobes are ignored: no bit is set and no result strobe appears. clr_i sampled while busy_o is high does not restart or lengthen the clear.
- R10: After reset, busy_o and res_valid_o are 0 and both vectors are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Request to wipe both vectors |
| busy_o | output | 1 | Clear in progress |
| prog_valid_i | input | 1 | Program strobe |
| prog_key_i | input | KEY_W | Key to insert |
| query_valid_i | input | 1 | Query strobe |
| query_key_i | input | KEY_W | Key to test |
| res_valid_o | output | 1 | Result strobe |
| res_hit_o | output | 1 | Primary vector result |
| res_match_o | output | 1 | Result confirmed by reference vector |

## Verification
The bench builds the block with KEY_W = 16, M = 64 and K = 4. Its vectors are small enough that a dozen keys make random primary false positives common, so the case where the reference vector rejects a primary hit is reached often. The bench also finds such keys on purpose. With M = 64 a full clear lasts only 64 cycles, which lets the bench count the busy window exactly and inject programs, queries and a second clear request inside it.

// File: rtl/bloom_pkg.sv
package bloom_pkg;
  // Full 32-bit H3 coefficient product; callers take the top index bits.
  function automatic logic [31:0] h3_coef(int unsigned sel, int unsigned bit_i);
    logic [31:0] seed;
    seed = 32'(sel * 256 + bit_i + 1);
    return seed * 32'h9E37_79B1;
  endfunction
endpackage

// File: rtl/bloom_h3_hash.sv
module bloom_h3_hash #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 10,
  parameter int SEL   = 0
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [KEY_W-1:0][IDX_W-1:0] coef;

  for (genvar b = 0; b < KEY_W; b++) begin : g_coef
    localparam logic [31:0] FULL = bloom_pkg::h3_coef(SEL, b);
    assign coef[b] = FULL[31 -: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int b = 0; b < KEY_W; b++) begin
      if (key_i[b]) idx_o ^= coef[b];
    end
  end
endmodule

// File: rtl/bloom_bitvec.sv
module bloom_bitvec #(
  parameter int M     = 1024,
  parameter int IDX_W = 10,
  parameter int NP    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      set_en_i,
  input  logic [NP-1:0][IDX_W-1:0]  set_idx_i,
  input  logic                      clr_en_i,
  input  logic [IDX_W-1:0]          clr_idx_i,
  input  logic [NP-1:0][IDX_W-1:0]  rd_idx_i,
  output logic [NP-1:0]             rd_bit_o
);
  logic [M-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
    end else begin
      if (clr_en_i) vec_q[clr_idx_i] <= 1'b0;
      if (set_en_i) begin
        for (int p = 0; p < NP; p++) vec_q[set_idx_i[p]] <= 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rd_bit_o[p] = vec_q[rd_idx_i[p]];
  end
endmodule

// File: rtl/bloom_ref_filter.sv
module bloom_ref_filter #(
  parameter int KEY_W = 32,
  parameter int M     = 1024,  // power of two
  parameter int K     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic             busy_o,
  input  logic             prog_valid_i,
  input  logic [KEY_W-1:0] prog_key_i,
  input  logic             query_valid_i,
  input  logic [KEY_W-1:0] query_key_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic             res_match_o
);
  localparam int IDX_W = $clog2(M);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(M - 1);

  logic [K-1:0][IDX_W-1:0] prog_idx, qry_idx;
  logic [IDX_W-1:0]        prog_ref_idx, qry_ref_idx;
  logic [K-1:0]            prim_bits;
  logic                    ref_bit;

  for (genvar g = 0; g < K; g++) begin : g_hash
    bloom_h3_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SEL(g)) u_prog_hash (
      .key_i(prog_key_i), .idx_o(prog_idx[g]));
    bloom_h3_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SEL(g)) u_qry_hash (
      .key_i(query_key_i), .idx_o(qry_idx[g]));
  end

  always_comb begin
    prog_ref_idx = '0;
    qry_ref_idx  = '0;
    for (int g = 0; g < K; g++) begin
      prog_ref_idx ^= prog_idx[g];
      qry_ref_idx  ^= qry_idx[g];
    end
  end

  // Clear sequencer
  logic             busy_q;
  logic [IDX_W-1:0] clr_cnt_q;
  logic             start_clr, prog_en, qry_en;

  assign start_clr = clr_i & ~busy_q;
  assign prog_en   = prog_valid_i  & ~busy_q & ~clr_i;
  assign qry_en    = query_valid_i & ~busy_q & ~clr_i;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      clr_cnt_q <= '0;
    end else if (start_clr) begin
      busy_q    <= 1'b1;
      clr_cnt_q <= '0;
    end else if (busy_q) begin
      if (clr_cnt_q == LAST_IDX) busy_q <= 1'b0;
      clr_cnt_q <= clr_cnt_q + 1'b1;
    end
  end

  // Storage
  logic [IDX_W-1:0] ref_idx_q;

  bloom_bitvec #(.M(M), .IDX_W(IDX_W), .NP(K)) u_prim_vec (
    .clk_i, .rst_ni,
    .set_en_i (prog_en),
    .set_idx_i(prog_idx),
    .clr_en_i (busy_q),
    .clr_idx_i(clr_cnt_q),
    .rd_idx_i (qry_idx),
    .rd_bit_o (prim_bits)
  );

  bloom_bitvec #(.M(M), .IDX_W(IDX_W), .NP(1)) u_ref_vec (
    .clk_i, .rst_ni,
    .set_en_i (prog_en),
    .set_idx_i(prog_ref_idx),
    .clr_en_i (busy_q),
    .clr_idx_i(clr_cnt_q),
    .rd_idx_i (ref_idx_q),
    .rd_bit_o (ref_bit)
  );

  // Stage 1: primary lookup; reference address loaded only on a hit
  logic s1_valid_q, s1_hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_hit_q   <= 1'b0;
      ref_idx_q  <= '0;
    end else begin
      s1_valid_q <= qry_en;
      s1_hit_q   <= qry_en & (&prim_bits);
      if (qry_en && (&prim_bits)) ref_idx_q <= qry_ref_idx;
    end
  end

  // Stage 2: reference verification
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_match_o <= 1'b0;
    end else begin
      res_valid_o <= s1_valid_q;
      res_hit_o   <= s1_hit_q;
      res_match_o <= s1_hit_q & ref_bit;
    end
  end
endmodule

// File: rtl/bloom_ref_filter_chk.sv
module bloom_ref_filter_chk #(
  parameter int M = 1024
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic busy_o,
  input logic query_valid_i,
  input logic res_valid_o,
  input logic res_hit_o,
  input logic res_match_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  assert_match_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_match_o |-> res_hit_o);

  assert_quiet_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_hit_o && !res_match_o));

  assert_strobe_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(query_valid_i && !busy_o && !clr_i) |=> res_valid_o);

  assert_no_result_when_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!query_valid_i || busy_o || clr_i) |=> !res_valid_o);

  assert_busy_from_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(clr_i));

  assert_busy_length_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == M));
endmodule

bind bloom_ref_filter bloom_ref_filter_chk #(.M(M)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .busy_o       (busy_o),
  .query_valid_i(query_valid_i),
  .res_valid_o  (res_valid_o),
  .res_hit_o    (res_hit_o),
  .res_match_o  (res_match_o)
);

// File: tb/tb_bloom_ref_filter.sv
module tb_bloom_ref_filter;
  localparam int KEY_W = 16;
  localparam int M     = 64;
  localparam int K     = 4;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic prog_valid_i = 1'b0;
  logic query_valid_i = 1'b0;
  logic [KEY_W-1:0] prog_key_i = '0;
  logic [KEY_W-1:0] query_key_i = '0;
  logic busy_o, res_valid_o, res_hit_o, res_match_o;

  int checks = 0;
  int errors = 0;
  bit pm [M];
  bit rm [M];
  logic [KEY_W-1:0] keys [12];

  always #4 clk = ~clk;

  bloom_ref_filter #(.KEY_W(KEY_W), .M(M), .K(K)) dut (
    .clk_i(clk), .rst_ni, .clr_i, .busy_o,
    .prog_valid_i, .prog_key_i, .query_valid_i, .query_key_i,
    .res_valid_o, .res_hit_o, .res_match_o
  );

  // R1 coefficient rule
  function automatic logic [IDX_W-1:0] ref_hash(int s, logic [KEY_W-1:0] key);
    logic [IDX_W-1:0] acc = '0;
    for (int b = 0; b < KEY_W; b++) begin
      logic [31:0] prod = 32'(256 * s + b + 1) * 32'h9E37_79B1;
      if (key[b]) acc ^= prod[31 -: IDX_W];
    end
    return acc;
  endfunction

  function automatic bit exp_hit(logic [KEY_W-1:0] key);
    bit h = 1'b1;
    for (int s = 0; s < K; s++) h &= pm[ref_hash(s, key)];
    return h;
  endfunction

  function automatic bit exp_ref(logic [KEY_W-1:0] key);
    logic [IDX_W-1:0] x = '0;
    for (int s = 0; s < K; s++) x ^= ref_hash(s, key);
    return rm[x];
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic model_prog(logic [KEY_W-1:0] key);
    logic [IDX_W-1:0] x = '0;
    for (int s = 0; s < K; s++) begin
      pm[ref_hash(s, key)] = 1'b1;
      x ^= ref_hash(s, key);
    end
    rm[x] = 1'b1;
  endtask

  task automatic model_clear();
    for (int i = 0; i < M; i++) begin pm[i] = 1'b0; rm[i] = 1'b0; end
  endtask

  task automatic do_prog(logic [KEY_W-1:0] key);
    @(negedge clk);
    prog_valid_i = 1'b1; prog_key_i = key;
    @(negedge clk);
    prog_valid_i = 1'b0;
    model_prog(key);
  endtask

  task automatic do_query(logic [KEY_W-1:0] key, string req);
    bit eh = exp_hit(key);
    bit em = eh & exp_ref(key);
    @(negedge clk);
    query_valid_i = 1'b1; query_key_i = key;
    @(negedge clk);
    query_valid_i = 1'b0;
    check("R3", "no strobe after one edge", res_valid_o, 1'b0);
    @(negedge clk);
    check("R3", "strobe after two edges", res_valid_o, 1'b1);
    check(req, "hit", res_hit_o, eh);
    check(req, "match", res_match_o, em);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int fp_seen;
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10", "busy after reset", busy_o, 1'b0);
    check("R10", "valid after reset", res_valid_o, 1'b0);
    do_query(16'hBEEF, "R10");
    do_query(16'h0000, "R6");

    // R2/R4: programmed keys always hit and match
    for (int i = 0; i < 12; i++) begin
      keys[i] = KEY_W'($urandom());
      do_prog(keys[i]);
    end
    for (int i = 0; i < 12; i++) do_query(keys[i], "R2 R4 R5");

    // R4/R5/R6: random queries against model
    fp_seen = 0;
    for (int i = 0; i < 300; i++) begin
      logic [KEY_W-1:0] k = KEY_W'($urandom());
      if (exp_hit(k) && !exp_ref(k)) fp_seen++;
      do_query(k, "R4 R5 R6");
    end

    // R5 directed: primary false positive rejected by reference
    for (int i = 0; i < 20000; i++) begin
      logic [KEY_W-1:0] k = KEY_W'($urandom());
      if (exp_hit(k) && !exp_ref(k)) begin
        do_query(k, "R5");
        check("R5", "rejected hit", res_hit_o & ~res_match_o, 1'b1);
        break;
      end
    end

    // R3: back-to-back queries
    @(negedge clk);
    query_valid_i = 1'b1; query_key_i = keys[0];
    @(negedge clk);
    query_key_i = 16'h1357;
    begin
      bit eh2 = exp_hit(16'h1357);
      bit em2 = eh2 & exp_ref(16'h1357);
      @(negedge clk);
      query_valid_i = 1'b0;
      check("R3", "first b2b strobe", res_valid_o, 1'b1);
      check("R3", "first b2b match", res_match_o, 1'b1);
      @(negedge clk);
      check("R3", "second b2b strobe", res_valid_o, 1'b1);
      check("R3", "second b2b hit", res_hit_o, eh2);
      check("R3", "second b2b match", res_match_o, em2);
      @(negedge clk);
      check("R3", "strobe ends", res_valid_o, 1'b0);
      check("R7", "hit low when idle", res_hit_o, 1'b0);
    end

    // R8/R9: clear with blocked traffic inside
    @(negedge clk);
    clr_i = 1'b1;
    query_valid_i = 1'b1; query_key_i = keys[1];
    prog_valid_i = 1'b1; prog_key_i = 16'hA5A5;
    @(negedge clk);
    clr_i = 1'b0; query_valid_i = 1'b0; prog_valid_i = 1'b0;
    cnt = 0;
    while (busy_o && cnt < 4 * M) begin
      cnt++;
      if (cnt == 3) begin prog_valid_i = 1'b1; prog_key_i = 16'h5A5A; end
      if (cnt == 4) begin prog_valid_i = 1'b0; query_valid_i = 1'b1; query_key_i = keys[2]; end
      if (cnt == 5) begin query_valid_i = 1'b0; clr_i = 1'b1; end
      if (cnt == 6) clr_i = 1'b0;
      if (cnt >= 2 && res_valid_o) check("R9", "strobe during busy", res_valid_o, 1'b0);
      @(negedge clk);
    end
    checks++;
    if (cnt != M) begin
      errors++;
      $display("FAIL R8 busy length: actual %0d expected %0d", cnt, M);
    end
    check("R9", "no late strobe", res_valid_o, 1'b0);
    model_clear();
    for (int i = 0; i < 12; i++) do_query(keys[i], "R8");
    do_query(16'hA5A5, "R9");
    do_query(16'h5A5A, "R9");

    // R2 after reload, plus random phase
    for (int i = 0; i < 8; i++) begin
      keys[i] = KEY_W'($urandom());
      do_prog(keys[i]);
    end
    for (int i = 0; i < 8; i++) do_query(keys[i], "R2 R4");
    for (int i = 0; i < 100; i++) do_query(KEY_W'($urandom()), "R4 R5 R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule